// File: doc/BRIEF.md
# Dataflow Tally Counters with Synchronous Freeze

This block sits at one point of a detector's control and data chain and keeps running totals of what passes it. It counts trigger strobes, calibration strobes and events sent on. It also keeps the length of the current unbroken run of sent events. Each counter wraps at its width and leaves a sticky overflow flag behind.

A freeze strobe is decoded upstream from the fast control stream and broadcast to many such blocks in the same clock cycle. On that strobe the block copies every live counter and every overflow flag into a shadow bank at once. Counts taken at different places can then be compared at the same instant. The live counters keep running, and the shadow bank keeps its values until the next freeze.

The control system reads the shadow bank through a small indexed read port. Each read returns its value one cycle after the request. A separate synchronous clear strobe zeroes the live counters and their flags but leaves the shadow bank as it was.

Top module: `flow_tally`

## Requirements
- R1: Each cycle with `trig_i` high adds one to the trigger counter (index 0).
- R2: Each cycle with `calib_i` high adds one to the calibration counter (index 1).
- R3: Each cycle with `evt_sent_i` high adds one to the sent-event counter (index 2).
- R4: The run counter (index 3) adds one on each cycle with `evt_sent_i` high. A cycle with `evt_miss_i` high sets it to zero, and this takes priority over `evt_sent_i` in the same cycle.
- R5: A cycle with `snap_i` high copies all four counters and all four overflow flags into the shadow bank in one cycle. The copy holds the values from before any increment or clear in that same cycle.
- R6: Between freezes the shadow bank keeps its values while the live counters keep counting.
- R7: A cycle with `clr_i` high zeroes all live counters and overflow flags, and the shadow bank is left unchanged. Clear takes priority over increments in the same cycle.
- R8: Counters are `CNT_W` bits wide (default 32) and wrap from all ones to zero. The wrap sets that counter's sticky overflow flag, which stays set until a clear or a reset.
- R9: Reading index 4 returns the shadow flags in bits [3:0] as trigger, calibration, sent-event and run (bit 0 to bit 3), with zero in the upper bits. Indices 5 to 7 read as zero.
- R10: A read request with `rd_en_i` high returns the selected shadow value on `rd_data_o` with `rd_valid_o` high one cycle later. `rd_valid_o` is low on cycles that follow no request.
- R11: After reset, all live counters, flags and shadow values read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trig_i | input | 1 | Trigger passed this point |
| calib_i | input | 1 | Calibration command passed this point |
| evt_sent_i | input | 1 | Event sent on |
| evt_miss_i | input | 1 | Event sequence broken; ends the run |
| snap_i | input | 1 | Freeze strobe: copy counters to shadow bank |
| clr_i | input | 1 | Synchronous clear of live counters and flags |
| rd_en_i | input | 1 | Read request |
| rd_idx_i | input | 3 | Shadow register index |
| rd_data_o | output | CNT_W | Read data |
| rd_valid_o | output | 1 | Read data valid |

## Verification
A counting strobe changes its counter at the next rising edge. A freeze strobe changes the shadow bank at that same edge. A read request places data on the outputs at the edge after it. The bench drives every strobe on a falling edge and keeps a model of the counters that it updates from the requirements. It issues a read on a later falling edge and samples the data and valid outputs on the falling edge after that, half a cycle after the register updates. Corner cases (increment and freeze together, miss and send together, clear and freeze together, and wrap with the counter narrowed to 8 bits) are each followed by reads that show their effect at the ports.

// File: rtl/flow_tally.sv
module flow_tally #(
  parameter int CNT_W = 32,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             calib_i,
  input  logic             evt_sent_i,
  input  logic             evt_miss_i,
  input  logic             snap_i,
  input  logic             clr_i,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             rd_valid_o
);
  localparam int NCNT = 4;
  localparam int RUN  = 3;

  logic [NCNT-1:0][CNT_W-1:0] live_q, shad_q;
  logic [NCNT-1:0]            ovf_q, ovf_shad_q;
  logic [NCNT-1:0]            inc;
  logic [CNT_W-1:0]           rd_sel;

  assign inc = {evt_sent_i, evt_sent_i, calib_i, trig_i};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
        live_q[g] <= '0;
        ovf_q[g]  <= 1'b0;
      end else if (g == RUN && evt_miss_i) begin
        live_q[g] <= '0;
      end else if (inc[g]) begin
        live_q[g] <= live_q[g] + 1'b1;
        if (&live_q[g]) ovf_q[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shad_q     <= '0;
      ovf_shad_q <= '0;
    end else if (snap_i) begin
      shad_q     <= live_q;
      ovf_shad_q <= ovf_q;
    end
  end

  always_comb begin
    rd_sel = '0;
    if (rd_idx_i < IDX_W'(NCNT)) rd_sel = shad_q[rd_idx_i[1:0]];
    else if (rd_idx_i == IDX_W'(NCNT)) rd_sel[NCNT-1:0] = ovf_shad_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_sel;
    end
  end
endmodule

module flow_tally_chk #(
  parameter int CNT_W = 32,
  parameter int NCNT  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       trig_i,
  input logic                       calib_i,
  input logic                       evt_sent_i,
  input logic                       evt_miss_i,
  input logic                       snap_i,
  input logic                       clr_i,
  input logic                       rd_en_i,
  input logic                       rd_valid_o,
  input logic [NCNT-1:0][CNT_W-1:0] live_q,
  input logic [NCNT-1:0][CNT_W-1:0] shad_q,
  input logic [NCNT-1:0]            ovf_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assert_trig_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !clr_i) |=> live_q[0] == $past(live_q[0]) + ONE);
  assert_calib_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (calib_i && !clr_i) |=> live_q[1] == $past(live_q[1]) + ONE);
  assert_evt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_sent_i && !clr_i) |=> live_q[2] == $past(live_q[2]) + ONE);
  assert_run_break_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_miss_i |=> live_q[3] == '0);
  assert_snap_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    snap_i |=> shad_q == $past(live_q));
  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_i |=> $stable(shad_q));
  assert_clr_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (live_q == '0 && ovf_q == '0));
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (ovf_q & $past(ovf_q)) == $past(ovf_q));
  assert_rd_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);
  assert_rd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rd_valid_o);
endmodule

bind flow_tally flow_tally_chk #(.CNT_W(CNT_W), .NCNT(NCNT)) u_chk (.*);

// File: tb/test_flow_tally.sv
module test_flow_tally;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic trig_i = 0, calib_i = 0, evt_sent_i = 0, evt_miss_i = 0, snap_i = 0, clr_i = 0, rd_en_i = 0;
  logic [2:0]   rd_idx_i = '0;
  logic [W-1:0] rd_data_o;
  logic         rd_valid_o;
  int total = 0, bad = 0;
  logic [W-1:0] mc[4], ms[4];
  logic [3:0]   mf, msf;

  always #4 clk = ~clk;

  flow_tally #(.CNT_W(W)) i_flow_tally (.*);

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit t, c, e, m, s, k);
    @(negedge clk);
    {trig_i, calib_i, evt_sent_i, evt_miss_i, snap_i, clr_i} = {t, c, e, m, s, k};
    rd_en_i = 0;
    if (s) begin
      for (int i = 0; i < 4; i++) ms[i] = mc[i];
      msf = mf;
    end
    if (k) begin
      for (int i = 0; i < 4; i++) mc[i] = '0;
      mf = '0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        bit step;
        step = (i == 0) ? t : (i == 1) ? c : e;
        if (i == 3 && m) mc[i] = '0;
        else if (step) begin
          if (mc[i] == '1) mf[i] = 1'b1;
          mc[i] = mc[i] + 1'b1;
        end
      end
    end
  endtask

  task automatic rd(input logic [2:0] idx, output logic [W-1:0] d);
    @(negedge clk);
    {trig_i, calib_i, evt_sent_i, evt_miss_i, snap_i, clr_i} = '0;
    rd_en_i = 1; rd_idx_i = idx;
    @(negedge clk);
    rd_en_i = 0;
    d = rd_data_o;
    check("R10 valid", {{(W-1){1'b0}}, rd_valid_o}, 1);
  endtask

  task automatic check_all(input string tag);
    logic [W-1:0] d;
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), d);
      check($sformatf("%s idx%0d", tag, i), d, ms[i]);
    end
    rd(3'd4, d);
    check({tag, " R9 flags"}, d, {{(W-4){1'b0}}, msf});
  endtask

  task automatic t_reset;
    check_all("R11 reset");
    @(negedge clk);
    check("R10 idle", {{(W-1){1'b0}}, rd_valid_o}, 0);
  endtask

  task automatic t_counting;
    cyc(1,0,0,0,0,0); cyc(1,1,0,0,0,0); cyc(0,1,1,0,0,0);
    cyc(0,0,1,0,0,0); cyc(1,0,1,0,0,0); cyc(0,0,0,0,1,0);
    check_all("R1 R2 R3 R4 count");
  endtask

  task automatic t_same_cycle;
    cyc(1,1,1,0,1,0);
    check_all("R5 pre-increment");
  endtask

  task automatic t_hold;
    logic [W-1:0] d;
    cyc(1,0,1,0,0,0); cyc(1,1,0,0,0,0);
    rd(3'd0, d);
    check("R6 hold", d, ms[0]);
    cyc(0,0,0,0,1,0);
    check_all("R6 refresh");
  endtask

  task automatic t_run;
    cyc(0,0,1,0,0,0); cyc(0,0,0,1,0,0); cyc(0,0,1,0,0,0);
    cyc(0,0,1,0,0,0); cyc(0,0,0,0,1,0);
    check_all("R4 run");
    cyc(0,0,1,1,0,0); cyc(0,0,0,0,1,0);
    check_all("R4 miss wins");
  endtask

  task automatic t_clear;
    cyc(1,0,1,0,1,1);
    check_all("R7 clear keeps shadow");
    cyc(0,0,0,0,1,0);
    check_all("R7 cleared");
  endtask

  task automatic t_wrap;
    logic [W-1:0] d;
    for (int i = 0; i < 258; i++) cyc(1,0,0,0,0,0);
    cyc(0,0,0,0,1,0);
    check_all("R8 wrap");
    cyc(0,0,0,0,0,1); cyc(0,0,0,0,1,0);
    rd(3'd4, d);
    check("R8 flag cleared", d, '0);
  endtask

  task automatic t_bad_idx;
    logic [W-1:0] d;
    cyc(1,1,1,0,1,0);
    for (int i = 5; i < 8; i++) begin
      rd(3'(i), d);
      check("R9 unused index", d, '0);
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin mc[i] = '0; ms[i] = '0; end
    mf = '0; msf = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_counting();
    t_same_cycle();
    t_hold();
    t_run();
    t_clear();
    t_wrap();
    t_bad_idx();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all requirements actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule